// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave through which a host reads and writes a small bank of configuration registers. The host drives a serial clock, an active-low select and a data line. The block samples input on the rising clock edge and drives read data on the falling edge. Read data goes out on a separate output line, or on the shared data line when three-wire mode is on. Each output line has its own enable.

Every access starts with an 8-bit command. The command gives the direction and a 5-bit register address. The addressed register's data bytes follow. The register's width decides how many bytes move. Register 0 holds two mode bits: one turns on the shared-line (three-wire) mode and one reverses the bit and byte order. Raising the select during an access pauses it. Eight rising clock edges with the select high return the port to waiting for a command.

Top module: `srp_top`

## Requirements
- R1: The command byte is the first 8 bits of an access. Bit 7 set means read and bit 7 clear means write. Bits 6 and 5 have no effect. Bits 4..0 are the register address.
- R2: The number of data bytes after the command depends only on the address. Mapped address a moves (a mod 4)+1 bytes, so address 0 moves 1 byte. An address at or above NUM_REGS moves 1 byte.
- R3: When register 0 bit 6 is clear (the reset state), the command and data go most significant bit first. A multi-byte register starts with its top byte.
- R4: When register 0 bit 6 is set, every bit goes least significant bit first, the command included. A multi-byte register starts with its bottom byte.
- R5: Read data bit k changes on the falling clock edge that comes just before the host's k-th data rising edge. The first read bit is therefore present after the falling edge that follows the eighth command bit.
- R6: With register 0 bit 7 clear, read data goes out on `sdo` with `sdo_oe` high, and `sdio_oe` stays low.
- R7: With register 0 bit 7 set, read data goes out on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low.
- R8: While `cs_n` is high, `sdo_oe` and `sdio_oe` are both low.
- R9: If `cs_n` is high for 1 to 7 rising edges in the middle of an access, the access keeps its bit and byte position and continues when `cs_n` returns low.
- R10: After 8 rising edges with `cs_n` high, the port is waiting for a fresh command byte.
- R11: A write changes the register only after its last data bit arrives. An access that R10 cuts short leaves the register as it was.
- R12: A read of an unmapped address returns all zeros, and a write to an unmapped address changes nothing.
- R13: All registers reset to zero. A mode change written to register 0 applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high pauses the access |
| sdio_in | input | 1 | Command and write data input |
| sdio_out | output | 1 | Read data on the shared line (three-wire mode) |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Read data on the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |

## Verification
The bench uses the default parameters: eight mapped registers and a maximum width of four bytes. With these, the 1-, 2-, 3- and 4-byte access lengths are all used, and addresses 8 to 31 are there to test unmapped handling. A behavioural model drives every bit and checks the enables and the read line in each clock period. It covers both orderings, both wire modes, short pauses in reads and writes, and an aborting pause in the middle of a write.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned ADDR_W   = 5;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned W     = 8 * MAX_BYTES,
  localparam int unsigned CNT_W = $clog2(W),
  localparam int unsigned NB_W  = $clog2(MAX_BYTES + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  input  logic              lsb_mode,
  input  logic [W-1:0]      rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [W-1:0]      wr_data,
  output phase_e            phase,
  output logic              rw_q,
  output logic              cur_bit
);
  // Width table: the addressed register alone sets the byte count.
  function automatic logic [NB_W-1:0] width_of(input logic [ADDR_W-1:0] a);
    if (int'(a) >= int'(NUM_REGS)) return NB_W'(1);
    return NB_W'((int'(a) % int'(MAX_BYTES)) + 1);
  endfunction

  // Read word placed so that its first outgoing bit sits at the shift end.
  function automatic logic [W-1:0] align_read(input logic [W-1:0] v,
                                               input logic [NB_W-1:0] nb,
                                               input logic lsb);
    if (lsb) return v;
    return v << (int'(W) - 8 * int'(nb));
  endfunction

  // Accumulated write bits moved down to bit 0.
  function automatic logic [W-1:0] align_write(input logic [W-1:0] acc_v,
                                                input logic [NB_W-1:0] nb,
                                                input logic lsb);
    if (lsb) return acc_v >> (int'(W) - 8 * int'(nb));
    return acc_v;
  endfunction

  logic [CNT_W-1:0]  bit_cnt;
  logic [3:0]        idle_cnt;
  logic [7:0]        cmd_sh;
  logic [W-1:0]      acc, rd_sh;
  logic [ADDR_W-1:0] addr_q;
  logic [NB_W-1:0]   nb_q;

  logic [7:0]   cmd_next;
  logic [W-1:0] acc_next;
  logic         cmd_done, last_data, xfer_done, resync_evt;

  assign cmd_next   = lsb_mode ? {din, cmd_sh[7:1]} : {cmd_sh[6:0], din};
  assign acc_next   = lsb_mode ? {din, acc[W-1:1]} : {acc[W-2:0], din};
  assign cmd_done   = !cs_n && phase == PH_CMD && bit_cnt == CNT_W'(CMD_BITS - 1);
  assign last_data  = bit_cnt == CNT_W'(8 * int'(nb_q) - 1);
  assign xfer_done  = !cs_n && phase == PH_DATA && last_data;
  assign resync_evt = cs_n && idle_cnt == 4'd7;

  assign rd_addr = cmd_next[ADDR_W-1:0];
  assign wr_en   = xfer_done && !rw_q;
  assign wr_addr = addr_q;
  assign wr_data = align_write(acc_next, nb_q, lsb_mode);
  assign cur_bit = lsb_mode ? rd_sh[0] : rd_sh[W-1];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      idle_cnt <= '0;
      cmd_sh   <= '0;
      acc      <= '0;
      rd_sh    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      nb_q     <= NB_W'(1);
    end else if (cs_n) begin
      if (idle_cnt != 4'd8) idle_cnt <= idle_cnt + 4'd1;
      if (resync_evt) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end
    end else begin
      idle_cnt <= '0;
      if (phase == PH_CMD) begin
        cmd_sh <= cmd_next;
        if (cmd_done) begin
          phase   <= PH_DATA;
          bit_cnt <= '0;
          rw_q    <= cmd_next[7];
          addr_q  <= cmd_next[ADDR_W-1:0];
          nb_q    <= width_of(cmd_next[ADDR_W-1:0]);
          acc     <= '0;
          rd_sh   <= align_read(rd_word, width_of(cmd_next[ADDR_W-1:0]), lsb_mode);
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end else begin
        acc   <= acc_next;
        rd_sh <= lsb_mode ? (rd_sh >> 1) : (rd_sh << 1);
        if (last_data) begin
          phase   <= PH_CMD;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  // R9
  pause_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs_n && idle_cnt != 4'd7) |=> ($stable(bit_cnt) && $stable(phase)));

  // R10
  resync_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    resync_evt |=> (phase == PH_CMD && bit_cnt == '0));

  // R1
  cmd_to_data_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cmd_done |=> (phase == PH_DATA && bit_cnt == '0));

  // R11
  commit_at_end_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |=> phase == PH_CMD);
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank
  import srp_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned W     = 8 * MAX_BYTES,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata,
  output logic              mode_3w,
  output logic              mode_lsb
);
  logic [W-1:0] regs [NUM_REGS];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_REGS); i++) regs[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < int'(NUM_REGS); i++)
        if (int'(waddr) == i) regs[i] <= wdata;
    end
  end

  assign rdata    = (int'(raddr) < int'(NUM_REGS)) ? regs[raddr[IDX_W-1:0]] : '0;
  assign mode_3w  = regs[0][7];
  assign mode_lsb = regs[0][6];
endmodule

// File: rtl/srp_txdrv.sv
module srp_txdrv
  import srp_pkg::*;
(
  input  logic   sclk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  phase_e phase,
  input  logic   rw_q,
  input  logic   cur_bit,
  input  logic   mode_3w,
  output logic   sdio_out,
  output logic   sdio_oe,
  output logic   sdo,
  output logic   sdo_oe
);
  logic out_q, oe_q;

  // Launch on the falling edge so the bit is settled at the next rise.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= cur_bit;
      oe_q  <= (phase == PH_DATA) && rw_q;
    end
  end

  assign sdo      = out_q;
  assign sdio_out = out_q;
  assign sdo_oe   = oe_q && !cs_n && !mode_3w;
  assign sdio_oe  = oe_q && !cs_n && mode_3w;

  // R5
  drive_only_read_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (sdo_oe || sdio_oe) |-> (phase == PH_DATA && rw_q));

  // R6
  one_line_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));
endmodule

// File: rtl/srp_top.sv
module srp_top
  import srp_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo,
  output logic sdo_oe
);
  localparam int unsigned W = 8 * MAX_BYTES;

  logic [W-1:0]      rd_word, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en, rw_q, cur_bit, mode_3w, mode_lsb;
  phase_e            phase;

  srp_ctrl #(.NUM_REGS(NUM_REGS), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(sdio_in),
    .lsb_mode(mode_lsb), .rd_word(rd_word), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase(phase), .rw_q(rw_q), .cur_bit(cur_bit)
  );

  srp_regbank #(.NUM_REGS(NUM_REGS), .MAX_BYTES(MAX_BYTES)) u_bank (
    .sclk(sclk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_word),
    .mode_3w(mode_3w), .mode_lsb(mode_lsb)
  );

  srp_txdrv u_tx (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .phase(phase),
    .rw_q(rw_q), .cur_bit(cur_bit), .mode_3w(mode_3w),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: tb/test_srp_top.sv
`timescale 1ns/1ps
module test_srp_top;
  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_oe;
  int n_cmp = 0, n_bad = 0;
  string tag = "R13";

  logic [31:0] mreg [0:7];
  bit m_lsb = 0, m_3w = 0;

  always #2.5 sclk = ~sclk;

  srp_top i_srp_top (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Byte count per address, written as an explicit table (R2).
  function automatic int bytes_of(input int a);
    case (a)
      0: return 1; 1: return 2; 2: return 3; 3: return 4;
      4: return 1; 5: return 2; 6: return 3; 7: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic idle_check(input string req);
    #1;
    chk(req, {31'b0, sdo_oe}, 0);
    chk(req, {31'b0, sdio_oe}, 0);
  endtask

  // One bit period: drive after the falling edge, check before the rise (R5).
  task automatic send_bit(input bit b, input bit rd_bit, input bit exp_b);
    @(negedge sclk);
    #1 cs_n = 1'b0; sdio_in = b;
    #1;
    chk(m_3w ? "R7" : "R6", {31'b0, sdo_oe},  (rd_bit && !m_3w) ? 1 : 0);
    chk(m_3w ? "R7" : "R6", {31'b0, sdio_oe}, (rd_bit && m_3w) ? 1 : 0);
    if (rd_bit) chk({tag, "/R5"}, {31'b0, (m_3w ? sdio_out : sdo)}, {31'b0, exp_b});
  endtask

  task automatic hold_high(input int rises);
    @(negedge sclk);
    #1 cs_n = 1'b1;
    idle_check("R8");
    repeat (rises - 1) @(negedge sclk);
  endtask

  // pause_len 1..7 pauses at bit pause_at; 8 or more abandons the access there.
  task automatic xfer(input bit rd, input int addr, input logic [1:0] junk,
                      input logic [31:0] wdata, input int pause_at, input int pause_len);
    logic [7:0]  cmd;
    logic [31:0] exp_w;
    int n;
    cmd   = {rd, junk, addr[4:0]};
    n     = bytes_of(addr);
    exp_w = (addr < 8) ? mreg[addr] : 32'h0;
    for (int i = 0; i < 8 + 8 * n; i++) begin
      int idx;
      if (i == pause_at) begin
        if (pause_len >= 8) begin
          hold_high(pause_len);
          return;
        end
        hold_high(pause_len);
      end
      if (i < 8) begin
        idx = m_lsb ? i : 7 - i;
        send_bit(cmd[idx], 1'b0, 1'b0);
      end else begin
        idx = m_lsb ? (i - 8) : (8 * n - 1 - (i - 8));
        if (rd) send_bit(1'b0, 1'b1, exp_w[idx]);
        else    send_bit(wdata[idx], 1'b0, 1'b0);
      end
    end
    @(negedge sclk);
    #1 cs_n = 1'b1;
    idle_check("R8");
    // R13: a mode write applies to the next access.
    if (!rd && addr < 8) begin
      mreg[addr] = (n == 4) ? wdata : (wdata & ((32'd1 << (8 * n)) - 1));
      if (addr == 0) begin
        m_lsb = wdata[6];
        m_3w  = wdata[7];
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 32'h0;
    repeat (3) @(negedge sclk);
    idle_check("R13");
    #1 rst_n = 1'b1;

    tag = "R13"; xfer(1, 1, 2'b00, 0, -1, 0);
    xfer(1, 3, 2'b00, 0, -1, 0);

    // R1 R2 R3 R6 R11: MSB-first, four-wire, junk in bits 6..5
    tag = "R3";
    xfer(0, 1, 2'b11, 32'h0000A55A, -1, 0);
    xfer(0, 2, 2'b10, 32'h00C3E1F0, -1, 0);
    xfer(0, 3, 2'b01, 32'h89ABCDEF, -1, 0);
    xfer(0, 4, 2'b11, 32'h0000007E, -1, 0);
    tag = "R1";
    xfer(1, 1, 2'b11, 0, -1, 0);
    tag = "R2";
    xfer(1, 2, 2'b01, 0, -1, 0);
    xfer(1, 3, 2'b10, 0, -1, 0);
    xfer(1, 4, 2'b00, 0, -1, 0);

    // R12: unmapped addresses
    tag = "R12";
    xfer(0, 20, 2'b00, 32'h000000FF, -1, 0);
    xfer(1, 20, 2'b00, 0, -1, 0);
    xfer(1, 4, 2'b00, 0, -1, 0);

    // R9: short pauses in a read and a write
    tag = "R9";
    xfer(1, 3, 2'b00, 0, 14, 3);
    xfer(0, 2, 2'b00, 32'h00123456, 9, 7);
    xfer(1, 2, 2'b00, 0, 5, 1);

    // R10 R11: abandoned write leaves the register unchanged
    tag = "R11";
    xfer(0, 3, 2'b00, 32'h11111111, 13, 8);
    tag = "R10";
    xfer(1, 3, 2'b00, 0, -1, 0);
    xfer(0, 5, 2'b00, 32'h0000BEEF, 3, 9);
    xfer(1, 5, 2'b00, 0, -1, 0);

    // R4: least-significant-first ordering
    xfer(0, 0, 2'b00, 32'h00000040, -1, 0);
    tag = "R4";
    xfer(1, 3, 2'b00, 0, -1, 0);
    xfer(0, 1, 2'b00, 32'h0000C001, -1, 0);
    xfer(1, 1, 2'b00, 0, -1, 0);
    xfer(0, 7, 2'b01, 32'h0A0B0C0D, 20, 4);
    xfer(1, 7, 2'b00, 0, -1, 0);

    // R7: three-wire, both orderings
    xfer(0, 0, 2'b00, 32'h000000C5, -1, 0);
    tag = "R7";
    xfer(1, 2, 2'b00, 0, -1, 0);
    xfer(1, 0, 2'b00, 0, 11, 2);
    xfer(0, 0, 2'b00, 32'h00000080, -1, 0);
    xfer(1, 3, 2'b00, 0, -1, 0);
    xfer(1, 21, 2'b00, 0, -1, 0);

    // back to four-wire MSB-first
    xfer(0, 0, 2'b00, 32'h00000000, -1, 0);
    tag = "R6";
    xfer(1, 1, 2'b00, 0, -1, 0);
    xfer(1, 0, 2'b00, 0, -1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sclk);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule